// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms 20-bit physical memory addresses for a 16-bit processor that runs with segmented real-mode memory. It keeps four 16-bit segment base registers: code, stack, data and extra. Each one is loaded through a small write port. Every memory request arrives with a 16-bit offset, a code naming the base or index register that produced the offset, an access kind, and an optional segment override. The block picks the segment register that applies and forms the address as the segment value times sixteen plus the offset.

Segment selection is automatic. Instruction fetches always use the code segment. String-destination accesses always use the extra segment. Ordinary data accesses use the stack segment when the offset came from the stack pointer or the frame pointer, and the data segment otherwise. For ordinary data accesses only, an override replaces that default. The resulting address and a valid flag come out of a register one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address is (segment << 4) + offset, taken modulo 2^20. Example: code segment 0x0003 with offset 0x0007 gives 0x00037.
- R2: Access kind code 1 (instruction fetch) always uses the code segment. The base code and any override are ignored.
- R3: For ordinary data accesses with no override, base codes 0 (direct offset), 1 (BX), 2 (SI), 3 (DI) and 7 (reserved) use the data segment. Access kind codes 0 and 3 both count as ordinary data.
- R4: For ordinary data accesses with no override, base codes 4 (SP), 5 (BP) and 6 (BP combined with BX) use the stack segment.
- R5: Access kind code 2 (string destination) always uses the extra segment. The base code and any override are ignored.
- R6: On an ordinary data access with `req_ovr_en` high, the segment named by `req_ovr_seg` replaces the default. Segment codes are 0 code, 1 stack, 2 data, 3 extra.
- R7: A write on the segment port (`seg_wr_sel` uses the segment codes of R6) affects requests from the next cycle onward. A request in the same cycle as the write sees the old value.
- R8: `phys_valid` equals `req_valid` delayed by one cycle. `phys_addr` is updated only for a valid request and otherwise holds its value.
- R9: A synchronous reset clears all four segment registers, `phys_valid` and `phys_addr` to zero.
- R10: A carry out of bit 19 is discarded. Example: segment 0xFFFF with offset 0x0020 gives 0x00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (segment code) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request present |
| req_offset | input | 16 | Offset of the access |
| req_base | input | 3 | Code of the register that formed the offset |
| req_kind | input | 2 | Access kind: 0 data, 1 fetch, 2 string destination, 3 data |
| req_ovr_en | input | 1 | Segment override requested |
| req_ovr_seg | input | 2 | Override segment code |
| phys_valid | output | 1 | Registered request valid |
| phys_addr | output | 20 | Registered physical address |

## Verification
The bench covers these corner cases:
- A request in the same cycle as a write to its segment. A design that let the new value through early would produce an address built from the new segment.
- Overrides on fetches and on string destinations. A design that let an override win there would form code or extra addresses from the wrong base.
- The BP-plus-BX base code. A design that treated it as BX would land in the data segment.
- The wrap past 0xFFFFF. A design that kept the carry would show a misplaced high bit.
- Idle cycles between requests. A design that did not hold the address would let it drift.

The bench also runs a long random mix against the behavioural model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int NUM_SEG   = 4;
    localparam int SEG_ID_W  = $clog2(NUM_SEG);
    localparam int BASE_W    = 3;
    localparam int KIND_W    = 2;

    typedef enum logic [SEG_ID_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [BASE_W-1:0] {
        BASE_DIRECT = 3'd0,
        BASE_BX     = 3'd1,
        BASE_SI     = 3'd2,
        BASE_DI     = 3'd3,
        BASE_SP     = 3'd4,
        BASE_BP     = 3'd5,
        BASE_BP_BX  = 3'd6,
        BASE_RSVD   = 3'd7
    } base_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_DATA   = 2'd0,
        KIND_FETCH  = 2'd1,
        KIND_STRDST = 2'd2,
        KIND_DATA2  = 2'd3
    } kind_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [SEG_ID_W-1:0]               wr_sel,
    input  logic [SEG_W-1:0]                  wr_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0]     seg_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEG_W-1:0] seg;
    } rf_state_t;

    rf_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_en && (wr_sel == SEG_ID_W'(i))) begin
                state_d.seg[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_o = state_q.seg;

    AST_SEG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> seg_o[$past(wr_sel)] == $past(wr_data)); // R7

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_hold
        AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == SEG_ID_W'(g)) |=> $stable(seg_o[g])); // R7
    end

endmodule

// File: rtl/seg_selector.sv
module seg_selector
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [NUM_SEG-1:0][SEG_W-1:0] segs_i,
    input  logic [BASE_W-1:0]             base_i,
    input  logic [KIND_W-1:0]             kind_i,
    input  logic                          ovr_en_i,
    input  logic [SEG_ID_W-1:0]           ovr_seg_i,
    output logic [SEG_W-1:0]              seg_val_o
);

    seg_id_e pick;

    always_comb begin
        if (kind_i == KIND_FETCH) begin
            pick = SEG_CODE;
        end else if (kind_i == KIND_STRDST) begin
            pick = SEG_EXTRA;
        end else if (ovr_en_i) begin
            pick = seg_id_e'(ovr_seg_i);
        end else begin
            case (base_i)
                BASE_SP, BASE_BP, BASE_BP_BX: pick = SEG_STACK;
                default:                      pick = SEG_DATA;
            endcase
        end
    end

    assign seg_val_o = segs_i[pick];

endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] off_ext;
    logic [SUM_W-1:0] sum_full;

    assign base_ext = SUM_W'({seg_i, {SHIFT{1'b0}}});
    assign off_ext  = SUM_W'(off_i);
    assign sum_full = base_ext + off_ext;
    assign addr_o   = sum_full[ADDR_W-1:0];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seg_wr_en,
    input  logic [1:0]           seg_wr_sel,
    input  logic [SEG_W-1:0]     seg_wr_data,
    input  logic                 req_valid,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [2:0]           req_base,
    input  logic [1:0]           req_kind,
    input  logic                 req_ovr_en,
    input  logic [1:0]           req_ovr_seg,
    output logic                 phys_valid,
    output logic [ADDR_W-1:0]    phys_addr
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } out_state_t;

    out_state_t out_d, out_q;

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals;
    logic [SEG_W-1:0]              seg_pick;
    logic [ADDR_W-1:0]             addr_sum;

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_o   (seg_vals)
    );

    seg_selector #(.SEG_W(SEG_W)) u_sel (
        .segs_i    (seg_vals),
        .base_i    (req_base),
        .kind_i    (req_kind),
        .ovr_en_i  (req_ovr_en),
        .ovr_seg_i (req_ovr_seg),
        .seg_val_o (seg_pick)
    );

    seg_addr_adder #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT),
        .ADDR_W (ADDR_W)
    ) u_add (
        .seg_i  (seg_pick),
        .off_i  (req_offset),
        .addr_o (addr_sum)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_valid;
        if (req_valid) begin
            out_d.addr = addr_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign phys_valid = out_q.valid;
    assign phys_addr  = out_q.addr;

    function automatic logic [ADDR_W-1:0] expect_addr(input logic [SEG_W-1:0] s,
                                                      input logic [OFF_W-1:0] o);
        return {s, {SHIFT{1'b0}}} + ADDR_W'(o);
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> phys_valid); // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !phys_valid); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(phys_addr)); // R8
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == KIND_FETCH) |=>
            phys_addr == expect_addr($past(seg_vals[SEG_CODE]), $past(req_offset))); // R2
    AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == KIND_STRDST) |=>
            phys_addr == expect_addr($past(seg_vals[SEG_EXTRA]), $past(req_offset))); // R5
    AST_OVR_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ovr_en && (req_kind == KIND_DATA || req_kind == KIND_DATA2)) |=>
            phys_addr == expect_addr($past(seg_vals[req_ovr_seg]), $past(req_offset))); // R6

endmodule

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_offset = '0;
    logic [2:0]  req_base = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_seg = '0;
    logic        phys_valid;
    logic [19:0] phys_addr;

    always #4 clk = ~clk;

    seg_addr_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .req_valid   (req_valid),
        .req_offset  (req_offset),
        .req_base    (req_base),
        .req_kind    (req_kind),
        .req_ovr_en  (req_ovr_en),
        .req_ovr_seg (req_ovr_seg),
        .phys_valid  (phys_valid),
        .phys_addr   (phys_addr)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    int    model_seg [4];
    int    exp_valid = 0;
    int    exp_addr = 0;
    string exp_tag = "R9";

    task automatic check(input string what, input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick_seg(input int base, input int kind, input int oe, input int os);
        if (kind == 1) return 0;
        if (kind == 2) return 3;
        if (oe != 0) return os;
        if (base == 4 || base == 5 || base == 6) return 1;
        return 2;
    endfunction

    task automatic cycle(input bit we, input int ws, input int wd,
                         input bit rv, input int off, input int base, input int kind,
                         input bit oe, input int os, input string tag);
        @(negedge clk);
        check("phys_valid", int'(phys_valid), exp_valid, exp_tag);
        check("phys_addr", int'(phys_addr), exp_addr, exp_tag);
        if (rv) begin
            exp_addr = ((model_seg[pick_seg(base, kind, oe, os)] * 16) + off) % (1 << 20);
        end
        exp_valid = rv ? 1 : 0;
        exp_tag = tag;
        if (we) model_seg[ws] = wd;
        seg_wr_en   = we;
        seg_wr_sel  = 2'(ws);
        seg_wr_data = 16'(wd);
        req_valid   = rv;
        req_offset  = 16'(off);
        req_base    = 3'(base);
        req_kind    = 2'(kind);
        req_ovr_en  = oe;
        req_ovr_seg = 2'(os);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        seg_wr_en = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("phys_valid after reset", int'(phys_valid), 0, "R9");
        check("phys_addr after reset", int'(phys_addr), 0, "R9");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) model_seg[i] = 0;
        exp_valid = 0;
        exp_addr = 0;
        exp_tag = "R9";
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_seg[i] = 0;
        do_reset();
        // R9: segments are zero after reset, so the address equals the offset
        cycle(0, 0, 0, 1, 'h1234, 0, 0, 0, 0, "R9");
        cycle(0, 0, 0, 1, 'h0042, 4, 0, 0, 0, "R9");
        // R7: a write and a request to the same segment in one cycle
        cycle(1, 0, 3, 1, 7, 0, 1, 0, 0, "R7");
        cycle(0, 0, 0, 1, 7, 0, 1, 0, 0, "R1");
        cycle(1, 1, 'h1000, 0, 0, 0, 0, 0, 0, "R8");
        cycle(1, 2, 'h2000, 0, 0, 0, 0, 0, 0, "R8");
        cycle(1, 3, 'h3000, 0, 0, 0, 0, 0, 0, "R8");
        // R3: data-segment bases
        cycle(0, 0, 0, 1, 'h0010, 1, 0, 0, 0, "R3");
        cycle(0, 0, 0, 1, 'h0020, 2, 0, 0, 0, "R3");
        cycle(0, 0, 0, 1, 'h0030, 3, 0, 0, 0, "R3");
        cycle(0, 0, 0, 1, 'h0040, 0, 3, 0, 0, "R3");
        cycle(0, 0, 0, 1, 'h0050, 7, 0, 0, 0, "R3");
        // R4: stack-segment bases
        cycle(0, 0, 0, 1, 'h0060, 4, 0, 0, 0, "R4");
        cycle(0, 0, 0, 1, 'h0070, 5, 0, 0, 0, "R4");
        cycle(0, 0, 0, 1, 'h0080, 6, 3, 0, 0, "R4");
        // R5 and R2: overrides ignored
        cycle(0, 0, 0, 1, 'h0090, 3, 2, 1, 0, "R5");
        cycle(0, 0, 0, 1, 'h00A0, 5, 1, 1, 2, "R2");
        // R6: overrides on data accesses
        cycle(0, 0, 0, 1, 'h00B0, 1, 0, 1, 0, "R6");
        cycle(0, 0, 0, 1, 'h00C0, 5, 0, 1, 2, "R6");
        cycle(0, 0, 0, 1, 'h00D0, 0, 3, 1, 3, "R6");
        // R8: idle cycles keep the previous address
        cycle(0, 0, 0, 0, 'hFFFF, 1, 0, 0, 0, "R8");
        cycle(0, 0, 0, 0, 'h1111, 4, 1, 0, 0, "R8");
        // R10: wrap past the top of the 20-bit space
        cycle(1, 2, 'hFFFF, 0, 0, 0, 0, 0, 0, "R8");
        cycle(0, 0, 0, 1, 'h0020, 1, 0, 0, 0, "R10");
        cycle(0, 0, 0, 1, 'hFFFF, 2, 0, 0, 0, "R10");
        // R1: random mix
        for (int k = 0; k < 600; k++) begin
            cycle(($urandom % 4) == 0, $urandom % 4, $urandom % 65536,
                  ($urandom % 5) != 0, $urandom % 65536, $urandom % 8, $urandom % 4,
                  $urandom % 2, $urandom % 4, "R1");
        end
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R9: mid-run reset clears the segments again
        do_reset();
        cycle(0, 0, 0, 1, 'h0ABC, 5, 0, 0, 0, "R9");
        cycle(0, 0, 0, 1, 'h0DEF, 3, 2, 0, 0, "R9");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule